// File: doc/BRIEF.md
# Error-Correcting On-Chip RAM with Hardware Zero-Fill

This block is a single-port on-chip RAM of 32-bit words. Each word is stored with 7 check bits of a Hamming single-error-correct, double-error-detect code. A small register bank sits on the same valid/ready bus. A RAM that powers up with random contents would flag errors on every location that has never been written. To prevent this, software starts a built-in fill engine. The engine writes zero data and zero check bits to every word, one word per clock. When it finishes it clears its own start bit and raises a done flag.

On reads with checking turned on, a single flipped bit is corrected in the returned data and a sticky single-error flag is set. Two flipped bits return the raw word and set a sticky double-error flag. Software clears both flags by writing 1 to them. An interrupt output combines the flags with an enable.

The intended bring-up order is:
1. Turn checking and the interrupt off.
2. Start the fill and poll the done flag.
3. Clear the pending flags.
4. Turn checking and the interrupt back on.

The fill engine is a three-state machine:
- `FS_IDLE` goes to `FS_FILL` when a start is accepted.
- `FS_FILL` steps the address every clock and goes to `FS_FINISH` after the last word.
- `FS_FINISH` lasts one cycle, sets done, clears start, and returns to `FS_IDLE`.

Top module: `ecc_ram_ctl`

## Requirements
- R1: After reset, every register reads 0, including control, fill status, interrupt enable and pending flags, and `irq` is low.
- R2: Control register (byte offset 0x08) bits [1:0] read back as written. Checking and correction are active only while both bits are 1. The values 01 and 10 behave as checking off.
- R3: Writing 1 to control bit 16 while the engine is idle writes data 0 and check bits 0 to every address, one per clock. Bit 16 reads 1 during the fill and clears itself when the fill ends.
- R4: Fill status (offset 0x0C) bit 0 is set when the fill ends. It stays set until the next accepted start, which clears it. Bit 8 always reads 0.
- R5: While the engine is busy, RAM requests (`bus_csr`=0) see `bus_ready` low for DEPTH+1 cycles, counted from the cycle after the start write. Register requests are accepted during this time, and a start written during a fill has no effect.
- R6: Every accepted read gives `rsp_valid` high for exactly one cycle, in the cycle after acceptance. A word written with checking on reads back unchanged and sets no flag.
- R7: A RAM write with checking off updates only the data bits; the stored check bits keep their old value. Reads with checking off return the stored data unchanged and set no flag.
- R8: With checking on, a word with one flipped bit returns corrected data and sets pending bit 0 (single error) at offset 0x20.
- R9: With checking on, a word with two flipped bits returns the raw stored data and sets pending bit 8 (double error).
- R10: Writing 1 to pending bit 0 or bit 8 clears that bit, and writing 0 leaves it. If a new error and a clear land in the same cycle, the new error wins and the flag stays set.
- R11: The interrupt-enable register (offset 0x10) has bit 0 as its only field. `irq` = (pending bit 0 AND enable) OR pending bit 8.
- R12: Register offsets other than 0x08, 0x0C, 0x10 and 0x20 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Request valid |
| bus_ready | output | 1 | Request accepted when high together with valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_csr | input | 1 | 1 = register bank (byte offset in bus_addr[5:0]), 0 = RAM (word index in bus_addr[AW-1:0]) |
| bus_addr | input | ADDR_W | Address |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Error interrupt |

## Verification
The assertions assume the bus master follows the handshake:
- it raises `bus_valid` with stable fields and holds them until `bus_ready` is seen;
- it issues at most one request at a time;
- it never reads a RAM word that has neither been filled nor written.

The stimulus keeps to these assumptions by driving every request through one task that waits for acceptance and then drops valid. The bench fills the RAM before any RAM read. It creates bit errors only through the documented path: data-only writes with checking off, made on top of a freshly filled array, so the stored check bits are known to be zero.

// File: rtl/ecc_ram_pkg.sv
package ecc_ram_pkg;

    localparam int DATA_W   = 32;
    localparam int CHK_W    = 7;
    localparam int CODE_LEN = 38;   // Hamming positions 1..38 excluding overall parity

    localparam logic [5:0] OFS_CTRL = 6'h08;
    localparam logic [5:0] OFS_STAT = 6'h0C;
    localparam logic [5:0] OFS_IEN  = 6'h10;
    localparam logic [5:0] OFS_PEND = 6'h20;

    localparam int BIT_START = 16;
    localparam int BIT_DERR  = 8;

    typedef enum logic [1:0] {
        FS_IDLE   = 2'd0,
        FS_FILL   = 2'd1,
        FS_FINISH = 2'd2
    } fill_state_e;

    // Hamming position of data bit j (skips power-of-two positions).
    function automatic logic [5:0] data_pos(input int j);
        int         cnt;
        logic [5:0] p;
        cnt = 0;
        p   = '0;
        for (int q = 1; q <= CODE_LEN; q++) begin
            if ((q & (q - 1)) != 0) begin
                if (cnt == j) p = 6'(q);
                cnt++;
            end
        end
        return p;
    endfunction

    // Six Hamming parity bits over the data word.
    function automatic logic [5:0] hamming_par(input logic [DATA_W-1:0] d);
        logic [5:0] s;
        s = '0;
        for (int j = 0; j < DATA_W; j++) begin
            if (d[j]) s = s ^ data_pos(j);
        end
        return s;
    endfunction

endpackage

// File: rtl/ecc_secded_enc.sv
module ecc_secded_enc
    import ecc_ram_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o
);
    logic [5:0] par;

    always_comb begin
        par   = hamming_par(data_i);
        chk_o = {(^data_i) ^ (^par), par};
    end
endmodule

// File: rtl/ecc_secded_dec.sv
module ecc_secded_dec
    import ecc_ram_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  logic [CHK_W-1:0]  chk_i,
    output logic [DATA_W-1:0] data_fix_o,
    output logic              err_single_o,
    output logic              err_double_o
);
    logic [5:0] syn;
    logic       ovr;

    always_comb begin
        syn          = hamming_par(data_i) ^ chk_i[5:0];
        ovr          = (^data_i) ^ (^chk_i);
        err_single_o = ovr;
        err_double_o = !ovr && (syn != 6'd0);
        data_fix_o   = data_i;
        for (int j = 0; j < DATA_W; j++) begin
            if (ovr && (data_pos(j) == syn)) data_fix_o[j] = !data_i[j];
        end
    end
endmodule

// File: rtl/ecc_ram_store.sv
module ecc_ram_store
    import ecc_ram_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we_data,
    input  logic              we_chk,
    input  logic              re,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CHK_W-1:0]  wchk,
    output logic [DATA_W-1:0] q_data,
    output logic [CHK_W-1:0]  q_chk
);
    logic [DATA_W-1:0] data_mem [DEPTH];
    logic [CHK_W-1:0]  chk_mem  [DEPTH];

    always_ff @(posedge clk) begin
        if (we_data) data_mem[addr] <= wdata;
        if (we_chk)  chk_mem[addr]  <= wchk;
        if (re) begin
            q_data <= data_mem[addr];
            q_chk  <= chk_mem[addr];
        end
    end
endmodule

// File: rtl/ecc_ram_fill_fsm.sv
module ecc_ram_fill_fsm
    import ecc_ram_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    output logic          busy,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          finish
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    fill_state_e   state_q, state_d;
    logic [AW-1:0] addr_q, addr_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        unique case (state_q)
            FS_IDLE: begin
                if (go) begin
                    state_d = FS_FILL;
                    addr_d  = '0;
                end
            end
            FS_FILL: begin
                addr_d = addr_q + 1'b1;
                if (addr_q == LAST) state_d = FS_FINISH;
            end
            FS_FINISH: state_d = FS_IDLE;
            default:   state_d = FS_IDLE;
        endcase
    end

    always_comb begin
        busy    = (state_q != FS_IDLE);
        wr_en   = (state_q == FS_FILL);
        finish  = (state_q == FS_FINISH);
        wr_addr = addr_q;
    end
endmodule

// File: rtl/ecc_ram_csr.sv
module ecc_ram_csr
    import ecc_ram_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_stb,
    input  logic        rd_stb,
    input  logic [5:0]  offs,
    input  logic [31:0] wdata,
    input  logic        fill_busy,
    input  logic        fill_finish,
    input  logic        evt_single,
    input  logic        evt_double,
    output logic        ecc_on,
    output logic        start_go,
    output logic        init_done,
    output logic        pend_s,
    output logic        pend_d,
    output logic        irq,
    output logic [31:0] rdata_q
);
    logic [1:0]  en_q;
    logic        start_q, done_q, ien_q, pend_s_q, pend_d_q;
    logic [31:0] rd_val;
    logic        wr_ctrl, wr_ien, wr_pend;
    logic        unused_wbits;

    assign wr_ctrl  = wr_stb && (offs == OFS_CTRL);
    assign wr_ien   = wr_stb && (offs == OFS_IEN);
    assign wr_pend  = wr_stb && (offs == OFS_PEND);
    assign start_go = wr_ctrl && wdata[BIT_START] && !fill_busy;
    assign unused_wbits = ^{wdata[31:17], wdata[15:9], wdata[7:2]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= '0;
            start_q  <= 1'b0;
            done_q   <= 1'b0;
            ien_q    <= 1'b0;
            pend_s_q <= 1'b0;
            pend_d_q <= 1'b0;
        end else begin
            if (wr_ctrl) en_q <= wdata[1:0];
            if (start_go)         start_q <= 1'b1;
            else if (fill_finish) start_q <= 1'b0;
            if (start_go)         done_q <= 1'b0;
            else if (fill_finish) done_q <= 1'b1;
            if (wr_ien) ien_q <= wdata[0];
            if (evt_single)                      pend_s_q <= 1'b1;
            else if (wr_pend && wdata[0])        pend_s_q <= 1'b0;
            if (evt_double)                      pend_d_q <= 1'b1;
            else if (wr_pend && wdata[BIT_DERR]) pend_d_q <= 1'b0;
        end
    end

    always_comb begin
        rd_val = '0;
        case (offs)
            OFS_CTRL: begin
                rd_val[1:0]       = en_q;
                rd_val[BIT_START] = start_q;
            end
            OFS_STAT: rd_val[0] = done_q;
            OFS_IEN:  rd_val[0] = ien_q;
            OFS_PEND: begin
                rd_val[0]        = pend_s_q;
                rd_val[BIT_DERR] = pend_d_q;
            end
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_stb) rdata_q <= rd_val;
    end

    assign ecc_on    = (en_q == 2'b11);
    assign init_done = done_q;
    assign pend_s    = pend_s_q;
    assign pend_d    = pend_d_q;
    assign irq       = (pend_s_q && ien_q) || pend_d_q;
endmodule

// File: rtl/ecc_ram_ctl.sv
module ecc_ram_ctl
    import ecc_ram_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    output logic              bus_ready,
    input  logic              bus_write,
    input  logic              bus_csr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              irq
);
    localparam int AW = $clog2(DEPTH);

    logic          fill_busy, fill_we, fill_finish, start_go, ecc_on;
    logic [AW-1:0] fill_addr;
    logic          init_done, pend_s, pend_d;
    logic          acc, ram_wr, ram_rd;
    logic          st_we_d, st_we_c, st_re;
    logic [AW-1:0] st_addr;
    logic [31:0]   st_wdata, q_data, fix_data, csr_rdata;
    logic [6:0]    st_wchk, enc_chk, q_chk;
    logic          dec_single, dec_double;
    logic          rsp_q, rsp_ram_q, rsp_ecc_q;
    logic          evt_single, evt_double;
    logic          unused_addr;

    assign unused_addr = ^bus_addr;

    assign bus_ready = bus_csr || !fill_busy;
    assign acc       = bus_valid && bus_ready;
    assign ram_wr    = acc && !bus_csr && bus_write;
    assign ram_rd    = acc && !bus_csr && !bus_write;

    ecc_ram_fill_fsm #(.DEPTH(DEPTH)) fill_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (start_go),
        .busy    (fill_busy),
        .wr_en   (fill_we),
        .wr_addr (fill_addr),
        .finish  (fill_finish)
    );

    ecc_secded_enc enc_i (
        .data_i (bus_wdata),
        .chk_o  (enc_chk)
    );

    always_comb begin
        if (fill_we) begin
            st_we_d  = 1'b1;
            st_we_c  = 1'b1;
            st_addr  = fill_addr;
            st_wdata = '0;
            st_wchk  = '0;
        end else begin
            st_we_d  = ram_wr;
            st_we_c  = ram_wr && ecc_on;
            st_addr  = bus_addr[AW-1:0];
            st_wdata = bus_wdata;
            st_wchk  = enc_chk;
        end
    end
    assign st_re = ram_rd;

    ecc_ram_store #(.DEPTH(DEPTH)) store_i (
        .clk     (clk),
        .we_data (st_we_d),
        .we_chk  (st_we_c),
        .re      (st_re),
        .addr    (st_addr),
        .wdata   (st_wdata),
        .wchk    (st_wchk),
        .q_data  (q_data),
        .q_chk   (q_chk)
    );

    ecc_secded_dec dec_i (
        .data_i       (q_data),
        .chk_i        (q_chk),
        .data_fix_o   (fix_data),
        .err_single_o (dec_single),
        .err_double_o (dec_double)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q     <= 1'b0;
            rsp_ram_q <= 1'b0;
            rsp_ecc_q <= 1'b0;
        end else begin
            rsp_q     <= acc && !bus_write;
            rsp_ram_q <= ram_rd;
            rsp_ecc_q <= ecc_on;
        end
    end

    assign evt_single = rsp_q && rsp_ram_q && rsp_ecc_q && dec_single;
    assign evt_double = rsp_q && rsp_ram_q && rsp_ecc_q && dec_double;

    ecc_ram_csr csr_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (acc && bus_csr && bus_write),
        .rd_stb      (acc && bus_csr && !bus_write),
        .offs        (bus_addr[5:0]),
        .wdata       (bus_wdata),
        .fill_busy   (fill_busy),
        .fill_finish (fill_finish),
        .evt_single  (evt_single),
        .evt_double  (evt_double),
        .ecc_on      (ecc_on),
        .start_go    (start_go),
        .init_done   (init_done),
        .pend_s      (pend_s),
        .pend_d      (pend_d),
        .irq         (irq),
        .rdata_q     (csr_rdata)
    );

    assign rsp_valid = rsp_q;
    assign rsp_rdata = !rsp_ram_q ? csr_rdata : (rsp_ecc_q ? fix_data : q_data);
endmodule

// File: rtl/ecc_ram_ctl_chk.sv
module ecc_ram_ctl_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_ready,
    input logic              bus_write,
    input logic              bus_csr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              rsp_valid,
    input logic              irq,
    input logic              fill_busy,
    input logic              st_we_d,
    input logic              st_we_c,
    input logic [31:0]       st_wdata,
    input logic [6:0]        st_wchk,
    input logic              pend_s,
    input logic              pend_d,
    input logic              init_done
);
    logic acc, clr_s, start_wr;
    assign acc      = bus_valid && bus_ready;
    assign clr_s    = acc && bus_write && bus_csr && (bus_addr[5:0] == 6'h20) && bus_wdata[0];
    assign start_wr = acc && bus_write && bus_csr && (bus_addr[5:0] == 6'h08) && bus_wdata[16] && !fill_busy;

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !bus_write) |=> rsp_valid);                                    // R6
    AST_RSP_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(acc && !bus_write));                               // R6
    AST_FILL_STALLS_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_busy && bus_valid && !bus_csr) |-> !bus_ready);                  // R5
    AST_FILL_WRITES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_busy && st_we_d) |-> (st_wdata == '0 && st_wchk == '0 && st_we_c)); // R3
    AST_START_DROPS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> (!init_done && fill_busy));                               // R4
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_s && !clr_s) |=> pend_s);                                        // R10
    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend_s || pend_d));                                           // R11
endmodule

bind ecc_ram_ctl ecc_ram_ctl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_write (bus_write),
    .bus_csr   (bus_csr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rsp_valid (rsp_valid),
    .irq       (irq),
    .fill_busy (fill_busy),
    .st_we_d   (st_we_d),
    .st_we_c   (st_we_c),
    .st_wdata  (st_wdata),
    .st_wchk   (st_wchk),
    .pend_s    (pend_s),
    .pend_d    (pend_d),
    .init_done (init_done)
);

// File: tb/ecc_ram_ctl_tb_top.sv
module ecc_ram_ctl_tb_top;
    localparam int DEPTH  = 64;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0, bus_write = 1'b0, bus_csr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_ready, rsp_valid, irq;
    logic [31:0]       rsp_rdata;

    int vectors = 0;
    int fails   = 0;
    bit finished = 0;

    always #10 clk = !clk;   // 50 MHz

    ecc_ram_ctl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
        .bus_write(bus_write), .bus_csr(bus_csr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic csr, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_csr = csr; bus_addr = a; bus_wdata = d;
        #1;
        while (!bus_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_csr = 1'b0;
    endtask

    task automatic bus_rd(input logic csr, input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_csr = csr; bus_addr = a;
        #1;
        while (!bus_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        check("R6 rsp_valid", {31'd0, rsp_valid}, 32'd1);
        d = rsp_rdata;
        bus_valid = 1'b0; bus_csr = 1'b0;
        @(negedge clk);
        check("R6 single-cycle rsp", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic run_fill(input logic [1:0] en, output int stall);
        logic [31:0] d;
        bus_wr(1'b1, 8'h08, 32'h0001_0000 | {30'd0, en});
        #1;
        stall = 0;
        while (!bus_ready && stall < 1000) begin
            stall++;
            @(negedge clk); #1;
        end
        bus_rd(1'b1, 8'h0C, d);
        check("R4 done after fill", d, 32'h1);
        bus_rd(1'b1, 8'h08, d);
        check("R3 start self-clears", d, {30'd0, en});
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                fails++;
                vectors++;
                $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
                $finish;
            end
        end
    end

    function automatic logic [31:0] pat(input int a);
        return (32'(a) * 32'h9E37_79B1) ^ (32'(a) << 7) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [31:0] dbl(input int k);
        return (32'd1 << k) | (32'd1 << ((k + 7) % 32));
    endfunction

    initial begin
        logic [31:0] d;
        int stall;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq reset", {31'd0, irq}, 32'd0);
        bus_rd(1'b1, 8'h08, d); check("R1 ctrl reset", d, 0);
        bus_rd(1'b1, 8'h0C, d); check("R1 stat reset", d, 0);
        bus_rd(1'b1, 8'h10, d); check("R1 ien reset", d, 0);
        bus_rd(1'b1, 8'h20, d); check("R1 pend reset", d, 0);

        // R12 unmapped offsets
        bus_wr(1'b1, 8'h04, 32'hFFFF_FFFF);
        bus_wr(1'b1, 8'h3C, 32'hFFFF_FFFF);
        bus_rd(1'b1, 8'h04, d); check("R12 unmapped 04", d, 0);
        bus_rd(1'b1, 8'h3C, d); check("R12 unmapped 3C", d, 0);
        bus_rd(1'b1, 8'h08, d); check("R12 ctrl untouched", d, 0);
        bus_rd(1'b1, 8'h10, d); check("R12 ien untouched", d, 0);

        // R3/R4/R5 first fill with checking off
        run_fill(2'b00, stall);
        check("R5 stall length", 32'(stall), 32'(DEPTH + 1));
        bus_rd(1'b1, 8'h0C, d); check("R4 done sticky", d, 32'h1);

        // R2 readback
        bus_wr(1'b1, 8'h08, 32'h3);
        bus_rd(1'b1, 8'h08, d); check("R2 ctrl readback", d, 32'h3);

        // R3 zero fill visible with checking on, no flags
        for (int a = 0; a < DEPTH; a++) begin
            bus_rd(1'b0, 8'(a), d); check("R3 zero after fill", d, 0);
        end
        bus_rd(1'b1, 8'h20, d); check("R3 no flags after fill", d, 0);

        // R6 round trip with checking on
        for (int a = 0; a < DEPTH; a++) bus_wr(1'b0, 8'(a), pat(a));
        for (int a = 0; a < DEPTH; a++) begin
            bus_rd(1'b0, 8'(a), d); check("R6 round trip", d, pat(a));
        end
        bus_rd(1'b1, 8'h20, d); check("R6 no flags", d, 0);

        // Second fill, observed mid-flight (R3/R4/R5)
        bus_wr(1'b1, 8'h08, 32'h0001_0000);
        bus_rd(1'b1, 8'h08, d); check("R3 start reads 1 during fill", d, 32'h0001_0000);
        bus_rd(1'b1, 8'h0C, d); check("R4 done cleared by start", d, 0);
        bus_wr(1'b1, 8'h08, 32'h0001_0000);   // ignored restart
        begin
            int guard = 0;
            d = 0;
            while (d[0] == 1'b0 && guard < 500) begin
                bus_rd(1'b1, 8'h0C, d); guard++;
            end
        end
        check("R5 fill completes", d, 32'h1);
        for (int a = 0; a < DEPTH; a += 9) begin
            bus_rd(1'b0, 8'(a), d); check("R3 refilled zero", d, 0);
        end

        // R7 data-only writes with checking off
        for (int j = 0; j < 32; j++)  bus_wr(1'b0, 8'(j), 32'd1 << j);
        for (int k = 0; k < 32; k++)  bus_wr(1'b0, 8'(32 + k), dbl(k));
        for (int j = 0; j < 32; j++) begin
            bus_rd(1'b0, 8'(j), d); check("R7 raw read off", d, 32'd1 << j);
        end
        bus_rd(1'b1, 8'h20, d); check("R7 no flags off", d, 0);

        // R2 partial enable behaves as off
        bus_wr(1'b1, 8'h08, 32'h1);
        bus_rd(1'b0, 8'd5, d); check("R2 en=01 raw", d, 32'd1 << 5);
        bus_wr(1'b1, 8'h08, 32'h2);
        bus_rd(1'b0, 8'd40, d); check("R2 en=10 raw", d, dbl(8));
        bus_rd(1'b1, 8'h20, d); check("R2 no flags partial", d, 0);

        // R8 single-bit correction on every data bit
        bus_wr(1'b1, 8'h08, 32'h3);
        for (int j = 0; j < 32; j++) begin
            bus_rd(1'b0, 8'(j), d); check("R8 corrected", d, 0);
            bus_rd(1'b1, 8'h20, d); check("R8 single flag", d, 32'h1);
            bus_wr(1'b1, 8'h20, 32'h1);
            bus_rd(1'b1, 8'h20, d); check("R10 w1c single", d, 0);
        end

        // R9 double-bit detection
        for (int k = 0; k < 32; k++) begin
            bus_rd(1'b0, 8'(32 + k), d); check("R9 raw on double", d, dbl(k));
            bus_rd(1'b1, 8'h20, d); check("R9 double flag", d, 32'h100);
            bus_wr(1'b1, 8'h20, 32'h0);
            bus_rd(1'b1, 8'h20, d); check("R10 write 0 keeps", d, 32'h100);
            bus_wr(1'b1, 8'h20, 32'h100);
            bus_rd(1'b1, 8'h20, d); check("R10 w1c double", d, 0);
        end

        // R11 interrupt
        bus_rd(1'b0, 8'd3, d);
        @(negedge clk); check("R11 irq masked", {31'd0, irq}, 0);
        bus_wr(1'b1, 8'h10, 32'h1);
        bus_rd(1'b1, 8'h10, d); check("R11 ien readback", d, 32'h1);
        check("R11 irq single enabled", {31'd0, irq}, 1);
        bus_wr(1'b1, 8'h20, 32'h1);
        @(negedge clk); check("R11 irq cleared", {31'd0, irq}, 0);
        bus_wr(1'b1, 8'h10, 32'h0);
        bus_rd(1'b0, 8'd33, d);
        @(negedge clk); check("R11 irq double unmasked", {31'd0, irq}, 1);
        bus_wr(1'b1, 8'h20, 32'h100);
        @(negedge clk); check("R11 irq low", {31'd0, irq}, 0);

        // R10 set wins over same-cycle clear
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_csr = 1'b0; bus_addr = 8'd7;
        @(negedge clk);
        check("R10 read corrected", rsp_rdata, 0);
        bus_write = 1'b1; bus_csr = 1'b1; bus_addr = 8'h20; bus_wdata = 32'h1;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_csr = 1'b0;
        bus_rd(1'b1, 8'h20, d); check("R10 set wins", d, 32'h1);
        bus_wr(1'b1, 8'h20, 32'h1);
        bus_rd(1'b1, 8'h20, d); check("R10 final clear", d, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule